// File: doc/BRIEF.md
# Address-Access Configured Memory Decoder

This block turns each 16-bit CPU bus address into a 3-bit device-select code that an external 1-of-8 decoder expands into ROM, RAM and I/O chip selects. Alongside the code it presents a memory-side address. For most regions this is the bus address unchanged. For the interrupt and reset vectors at the top of the map, it is bent down into the low ROM bank so that the vectors always come out of ROM.

The block has no data bus. Its configuration lives in eight control bits, and software changes them purely by touching addresses. Every bit has two neighbouring addresses in a small window near the top of memory. Touching the even address clears the bit and touching the odd one sets it. Seven of the bits form a 512-byte-aligned base for a video scan address counter. The eighth switches the map into an all-RAM layout in which RAM replaces both ROM banks. A gap separates the control window from the vector window, so the register decode never claims a vector.

The video counter is a two-state machine. In HOLD it keeps its value. The transition HOLD→SCAN on a start pulse loads the base. In SCAN the counter advances once per video step. The transition SCAN→SCAN on a start pulse reloads the base, and the transition SCAN→HOLD on a stop pulse freezes the count.

Top module: `addr_cfg_decoder`

## Requirements
- R1: Addresses $FFF2–$FFFF give select code 1 in either map mode, and the memory address equals the bus address with bit 14 cleared ($BFF2–$BFFF).
- R2: Addresses $0000–$7FFF give select code 0 in either mode, with the memory address equal to the bus address.
- R3: With control bit 7 at 0, $8000–$BFFF gives code 1 and $C000–$FEFF gives code 2. With bit 7 at 1, $8000–$FEFF gives code 0.
- R4: $FF00–$FFBF gives code 3 (I/O), $FFC0–$FFCF gives code 6 (control window) and $FFD0–$FFF1 gives code 7 (no device). The mode bit does not affect these.
- R5: A bus access (bus_valid high) to $FFC0+2n clears control bit n, and an access to $FFC1+2n sets it. The new value holds from the next clock edge.
- R6: Control bits do not change when a window address is presented with bus_valid low, or when bus_valid is high at an address outside $FFC0–$FFCF.
- R7: After reset all control bits are 0, the counter is in HOLD and vid_addr is $0000.
- R8: A vid_start pulse enters SCAN and loads vid_addr with {bits 6..0, 9'b0}, so bit n drives address bit 9+n. The value is visible after the next clock edge. Start takes priority over stop.
- R9: In SCAN, each cycle with vid_step high adds 1 to vid_addr, wrapping from $FFFF to $0000. In HOLD, vid_step has no effect.
- R10: A vid_stop pulse without vid_start moves SCAN→HOLD, and vid_addr then keeps its value.
- R11: dev_sel and mem_addr follow bus_addr combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A CPU access is in progress this cycle |
| bus_addr | input | 16 | CPU address |
| dev_sel | output | 3 | Device-select code for the 1-of-8 decoder |
| mem_addr | output | 16 | Memory-side address, vector window redirected |
| vid_start | input | 1 | Load the base and begin scanning |
| vid_stop | input | 1 | Freeze the scan counter |
| vid_step | input | 1 | Video-side low address bit advance |
| vid_addr | output | 16 | Video scan address |

## Verification
The control bits cannot be read back, so the difficult part is observing them at all. The bench shows the offset bits indirectly by pulsing vid_start and comparing the loaded vid_addr against a base it builds from its own copy of the set and clear accesses. It shows the mode bit through the select codes returned for ROM-range addresses. To check the stray-access case, the bench leaves a window address on the bus without bus_valid, and then performs a valid access to the I/O region. After both, it restarts the counter to confirm the base is unchanged. The scan wrap is reached by setting every offset bit, which gives a base of $FE00, and then stepping 512 times.

// File: rtl/acd_pkg.sv
package acd_pkg;
    localparam int ADDR_W   = 16;
    localparam int OFS_W    = 7;
    localparam int NUM_CTRL = 8;
    localparam int IDX_W    = $clog2(NUM_CTRL);
    localparam int MODE_BIT = 7;
    localparam int VEC_REMAP_BIT = 14;
    localparam int ALIGN_W  = ADDR_W - OFS_W;

    localparam logic [ADDR_W-1:0] ROM_LO_BASE = 16'h8000;
    localparam logic [ADDR_W-1:0] ROM_HI_BASE = 16'hC000;
    localparam logic [ADDR_W-1:0] IO_BASE     = 16'hFF00;
    localparam logic [ADDR_W-1:0] CTRL_BASE   = 16'hFFC0;
    localparam logic [ADDR_W-1:0] CTRL_END    = CTRL_BASE + ADDR_W'(2 * NUM_CTRL);
    localparam logic [ADDR_W-1:0] VEC_BASE    = 16'hFFF2;

    typedef enum logic [2:0] {
        SEL_RAM    = 3'd0,
        SEL_ROM_LO = 3'd1,
        SEL_ROM_HI = 3'd2,
        SEL_IO     = 3'd3,
        SEL_CTRL   = 3'd6,
        SEL_NONE   = 3'd7
    } dev_sel_e;

    typedef enum logic {
        VS_HOLD = 1'b0,
        VS_SCAN = 1'b1
    } vid_state_e;
endpackage

// File: rtl/acd_region_decode.sv
module acd_region_decode
    import acd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              all_ram,
    output dev_sel_e          sel,
    output logic [ADDR_W-1:0] maddr,
    output logic              in_ctrl
);
    always_comb begin
        maddr   = addr;
        in_ctrl = 1'b0;
        if (addr >= VEC_BASE) begin
            sel = SEL_ROM_LO;
            maddr[VEC_REMAP_BIT] = 1'b0;
        end else if (addr >= CTRL_END) begin
            sel = SEL_NONE;
        end else if (addr >= CTRL_BASE) begin
            sel     = SEL_CTRL;
            in_ctrl = 1'b1;
        end else if (addr >= IO_BASE) begin
            sel = SEL_IO;
        end else if (addr < ROM_LO_BASE || all_ram) begin
            sel = SEL_RAM;
        end else if (addr < ROM_HI_BASE) begin
            sel = SEL_ROM_LO;
        end else begin
            sel = SEL_ROM_HI;
        end
    end
endmodule

// File: rtl/acd_ctrl_bits.sv
module acd_ctrl_bits
    import acd_pkg::*;
#(
    parameter int N  = NUM_CTRL,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [IW-1:0] idx,
    input  logic          set_val,
    output logic [N-1:0]  bits_q
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q[g] <= 1'b0;
            end else if (hit && idx == IW'(g)) begin
                bits_q[g] <= set_val;
            end
        end
    end
endmodule

// File: rtl/acd_vid_counter.sv
module acd_vid_counter
    import acd_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic          step,
    input  logic [OW-1:0] base_ofs,
    output logic [AW-1:0] addr_q,
    output logic          run
);
    localparam int LOW_W = AW - OW;

    vid_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VS_HOLD: if (start) state_d = VS_SCAN;
            VS_SCAN: begin
                if (start)     state_d = VS_SCAN;
                else if (stop) state_d = VS_HOLD;
            end
            default: state_d = VS_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VS_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (start) begin
            addr_q <= {base_ofs, {LOW_W{1'b0}}};
        end else begin
            unique case (state_q)
                VS_HOLD: addr_q <= addr_q;
                VS_SCAN: if (step) addr_q <= addr_q + 1'b1;
                default: addr_q <= addr_q;
            endcase
        end
    end

    assign run = (state_q == VS_SCAN);
endmodule

// File: rtl/addr_cfg_decoder.sv
module addr_cfg_decoder
    import acd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        dev_sel,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              vid_start,
    input  logic              vid_stop,
    input  logic              vid_step,
    output logic [ADDR_W-1:0] vid_addr
);
    logic [NUM_CTRL-1:0] ctrl_q;
    logic                in_ctrl;
    logic                vid_run;
    dev_sel_e            sel;

    acd_region_decode u_dec (
        .addr    (bus_addr),
        .all_ram (ctrl_q[MODE_BIT]),
        .sel     (sel),
        .maddr   (mem_addr),
        .in_ctrl (in_ctrl)
    );

    acd_ctrl_bits #(.N(NUM_CTRL), .IW(IDX_W)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (bus_valid && in_ctrl),
        .idx     (bus_addr[IDX_W:1]),
        .set_val (bus_addr[0]),
        .bits_q  (ctrl_q)
    );

    acd_vid_counter #(.AW(ADDR_W), .OW(OFS_W)) u_vid (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (vid_start),
        .stop     (vid_stop),
        .step     (vid_step),
        .base_ofs (ctrl_q[OFS_W-1:0]),
        .addr_q   (vid_addr),
        .run      (vid_run)
    );

    assign dev_sel = sel;
endmodule

// File: rtl/addr_cfg_decoder_chk.sv
module addr_cfg_decoder_chk
    import acd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                bus_valid,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [2:0]          dev_sel,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                vid_start,
    input logic                vid_stop,
    input logic                vid_step,
    input logic [ADDR_W-1:0]   vid_addr,
    input logic [NUM_CTRL-1:0] ctrl_q,
    input logic                vid_run
);
    logic in_win;
    assign in_win = (bus_addr >= CTRL_BASE) && (bus_addr < CTRL_END);

    AST_VEC_TO_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= VEC_BASE) |-> (dev_sel == 3'd1 && mem_addr[VEC_REMAP_BIT] == 1'b0)); // R1
    AST_LOW_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < ROM_LO_BASE) |-> (dev_sel == 3'd0 && mem_addr == bus_addr)); // R2
    AST_CTRL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> (dev_sel == 3'd6)); // R4
    AST_SET_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && in_win && bus_addr[0]) |=> ctrl_q[$past(bus_addr[IDX_W:1])]); // R5
    AST_CLR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && in_win && !bus_addr[0]) |=> !ctrl_q[$past(bus_addr[IDX_W:1])]); // R5
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && in_win) |=> $stable(ctrl_q)); // R6
    AST_VID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        vid_start |=> (vid_run && vid_addr[ADDR_W-1:ALIGN_W] == $past(ctrl_q[OFS_W-1:0])
                       && vid_addr[ALIGN_W-1:0] == '0)); // R8
    AST_VID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_run && vid_step && !vid_start && !vid_stop) |=> (vid_addr == $past(vid_addr) + 1'b1)); // R9
    AST_VID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!vid_run && !vid_start) |=> $stable(vid_addr)); // R10
endmodule

bind addr_cfg_decoder addr_cfg_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .dev_sel   (dev_sel),
    .mem_addr  (mem_addr),
    .vid_start (vid_start),
    .vid_stop  (vid_stop),
    .vid_step  (vid_step),
    .vid_addr  (vid_addr),
    .ctrl_q    (ctrl_q),
    .vid_run   (vid_run)
);

// File: tb/test_addr_cfg_decoder.sv
`timescale 1ns/1ps
module test_addr_cfg_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [2:0]  dev_sel;
    logic [15:0] mem_addr;
    logic        vid_start = 1'b0;
    logic        vid_stop = 1'b0;
    logic        vid_step = 1'b0;
    logic [15:0] vid_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 dev_sel, 1 mem_addr, 2 vid_addr
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    logic [7:0] m_ctrl = 8'h00;

    always #2 clk = ~clk;

    addr_cfg_decoder i_addr_cfg_decoder (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .dev_sel(dev_sel), .mem_addr(mem_addr), .vid_start(vid_start),
        .vid_stop(vid_stop), .vid_step(vid_step), .vid_addr(vid_addr)
    );

    // monitor: one ns after each falling edge, well before the rising edge
    always begin
        @(negedge clk);
        #1;
        while (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = {13'b0, dev_sel};
                1:       act = mem_addr;
                default: act = vid_addr;
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    function automatic logic [2:0] exp_sel(input logic [15:0] a, input logic all_ram);
        if (a >= 16'hFFF2)      return 3'd1;  // R1
        else if (a >= 16'hFFD0) return 3'd7;  // R4
        else if (a >= 16'hFFC0) return 3'd6;  // R4
        else if (a >= 16'hFF00) return 3'd3;  // R4
        else if (a < 16'h8000)  return 3'd0;  // R2
        else if (all_ram)       return 3'd0;  // R3
        else if (a < 16'hC000)  return 3'd1;  // R3
        else                    return 3'd2;  // R3
    endfunction

    task automatic push(input int kind, input logic [15:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // driver: present an address with no access and queue the expected decode
    task automatic chk_dec(input logic [15:0] a, input string tag);
        logic [15:0] em;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_addr  = a;
        em = a;
        if (a >= 16'hFFF2) em[14] = 1'b0;
        push(0, {13'b0, exp_sel(a, m_ctrl[7])}, tag);
        push(1, em, tag);
    endtask

    task automatic bus_touch(input logic [15:0] a);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_addr  = a;
        if (a >= 16'hFFC0 && a < 16'hFFD0) m_ctrl[a[3:1]] = a[0];
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic vid_restart(input string tag);
        @(negedge clk);
        vid_start = 1'b1;
        @(negedge clk);
        vid_start = 1'b0;
        push(2, {m_ctrl[6:0], 9'b0}, tag);
    endtask

    task automatic vid_steps(input int n, input logic [15:0] exp, input string tag);
        @(negedge clk);
        vid_step = 1'b1;
        repeat (n) @(negedge clk);
        vid_step = 1'b0;
        push(2, exp, tag);
    endtask

    initial begin
        #20000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7 reset state
        @(negedge clk);
        push(2, 16'h0000, "R7 vid_addr after reset");
        chk_dec(16'h8000, "R7 mode bit clear after reset");
        vid_restart("R7 offset bits zero after reset");
        // R11 / R2 / R3 / R4 / R1 decode boundaries in split mode
        chk_dec(16'h0000, "R2 low RAM start");
        chk_dec(16'h7FFF, "R2 low RAM end");
        chk_dec(16'h8000, "R3 low ROM start");
        chk_dec(16'hBFFF, "R3 low ROM end");
        chk_dec(16'hC000, "R3 high ROM start");
        chk_dec(16'hFEFF, "R3 high ROM end");
        chk_dec(16'hFF00, "R4 I/O start");
        chk_dec(16'hFFBF, "R4 I/O end");
        chk_dec(16'hFFC0, "R4 control window start");
        chk_dec(16'hFFCF, "R4 control window end");
        chk_dec(16'hFFD0, "R4 gap start");
        chk_dec(16'hFFF1, "R4 gap end");
        chk_dec(16'hFFF2, "R1 vector window start");
        chk_dec(16'hFFFE, "R1 reset vector R11");
        chk_dec(16'hFFFF, "R1 vector window end");
        // R5 set mode bit, R3 all-RAM map
        bus_touch(16'hFFCF);
        chk_dec(16'h8000, "R3 all-RAM low ROM range");
        chk_dec(16'hFEFF, "R3 all-RAM high ROM range");
        chk_dec(16'hFFFE, "R1 vector in all-RAM mode");
        chk_dec(16'hFFC4, "R4 window in all-RAM mode");
        chk_dec(16'hFF10, "R4 I/O in all-RAM mode");
        // R6 window address without bus_valid, and valid access elsewhere
        @(negedge clk);
        bus_valid = 1'b0;
        bus_addr  = 16'hFFC1;
        repeat (2) @(negedge clk);
        bus_touch(16'hFF01);
        bus_touch(16'hFFD1);
        vid_restart("R6 offset untouched by stray accesses");
        chk_dec(16'hC000, "R6 mode bit kept");
        // R5 set offset bits 0 and 6, R8 load base
        bus_touch(16'hFFC1);
        bus_touch(16'hFFCD);
        vid_restart("R8 base 0x8200 loaded");
        // R9 stepping
        vid_steps(3, 16'h8203, "R9 three steps");
        // R10 stop then steps ignored
        @(negedge clk);
        vid_stop = 1'b1;
        @(negedge clk);
        vid_stop = 1'b0;
        vid_steps(5, 16'h8203, "R10 hold keeps value, R9 step ignored in HOLD");
        // R5 clear bit 6, start and stop together -> start wins
        bus_touch(16'hFFCC);
        @(negedge clk);
        vid_start = 1'b1;
        vid_stop  = 1'b1;
        @(negedge clk);
        vid_start = 1'b0;
        vid_stop  = 1'b0;
        push(2, 16'h0200, "R8 start over stop, bit 6 cleared R5");
        vid_steps(2, 16'h0202, "R8 still scanning after start+stop");
        // R9 wrap: all offset bits set
        for (int i = 0; i < 7; i++) bus_touch(16'hFFC1 + 16'(2 * i));
        vid_restart("R8 base 0xFE00");
        vid_steps(512, 16'h0000, "R9 wrap to zero");
        // R5 clear mode bit
        bus_touch(16'hFFCE);
        chk_dec(16'h8000, "R5 mode bit cleared, R3 ROM back");
        chk_dec(16'hC123, "R3 high ROM after clear");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule